// File: doc/BRIEF.md
# Serial Channel Host Register Bank

This block is the processor-facing register bank of a byte-oriented asynchronous serial channel. A host reaches it through a 3-bit address, separate read and write strobes and an active-low select. The bank stores the writable control registers (interrupt enables, queue control, line format, modem control, scratch and the 16-bit baud divisor). It passes status values in from the serializer, deserializer and interrupt logic, which sit outside the block.

A bank bit, bit 7 of the line format register, swaps the two divisor bytes into addresses 0 and 1. Several addresses read a different register from the one they write. The bank also tells its neighbours when the host takes a received byte or supplies a byte to send.

Top module: `uart_hostregs`

## Requirements
- R1: Synchronous active-high reset clears the interrupt-enable, queue-control, line-format and modem-control registers and both divisor bytes, so the bank bit starts clear. `rdata` is zero whenever no selected read is in progress.
- R2: With the bank bit clear, a read at address 0 returns `rx_byte` masked to the word length in line-format bits 1:0 (0 = 5 bits, 1 = 6, 2 = 7, 3 = 8). The unused upper bits read as zero.
- R3: With the bank bit clear, a write at address 0 raises `tx_load` for exactly the one cycle after the write edge, with `tx_byte` equal to the written byte. No register changes.
- R4: With the bank bit clear, address 1 reads and writes the interrupt-enable register, shown on `ien_o`.
- R5: With the bank bit set, address 0 reads and writes the divisor low byte and address 1 the high byte (`div_o` = {high, low}). Neither access produces `tx_load` or `rx_take`.
- R6: Address 2 returns `id_in` on read and loads the queue-control register (`fctl_o`) on write, whatever the bank bit.
- R7: Addresses 3 to 7 are line format, modem control, line status (`lstat_in`), modem status (`mstat_in`) and scratch, whatever the bank bit. Line format, modem control and scratch read back what was written.
- R8: Writes to addresses 5 and 6 change no register.
- R9: With `cs_n` high no write takes effect, no pulse is raised and `rdata` is zero.
- R10: A read at address 0 with the bank bit clear raises `rx_take` for exactly the one cycle after the read edge.
- R11: Read data is combinational: it is valid in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low channel select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| rx_byte | input | 8 | Received byte from the deserializer |
| id_in | input | 8 | Interrupt identification value |
| lstat_in | input | 8 | Line status value |
| mstat_in | input | 8 | Modem status value |
| tx_load | output | 1 | One-cycle pulse: host wrote a byte to send |
| tx_byte | output | 8 | Byte captured with tx_load |
| rx_take | output | 1 | One-cycle pulse: host read the received byte |
| ien_o | output | 8 | Interrupt-enable register |
| fctl_o | output | 8 | Queue-control register |
| lctl_o | output | 8 | Line-format register |
| mctl_o | output | 8 | Modem-control register |
| div_o | output | 16 | Baud divisor {high, low} |

## Verification
A stuck or wrongly decoded bank bit shows at once: the next access to address 0 or 1 reads the wrong register, and a write there moves `div_o` instead of pulsing `tx_load`, or the other way round. Any register that takes a write it should ignore shows on its output port one cycle after the edge. A misrouted read shows in the same cycle as the strobe. The bench sweeps every address under both bank settings, every word length against several received patterns, and selected and deselected strobes. It predicts each value from its own register model.

// File: rtl/uhr_pkg.sv
package uhr_pkg;
    localparam int DW      = 8;
    localparam int AW      = 3;
    localparam int BANK_BIT = 7;
    localparam int WL_W    = 2;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_IEN, SEL_IDFC, SEL_LCTL, SEL_MCTL,
        SEL_LSTAT, SEL_MSTAT, SEL_SCR, SEL_DIVLO, SEL_DIVHI
    } sel_e;

    typedef struct packed {
        logic [DW-1:0] ien;
        logic [DW-1:0] fctl;
        logic [DW-1:0] lctl;
        logic [DW-1:0] mctl;
        logic [DW-1:0] divlo;
        logic [DW-1:0] divhi;
    } regs_t;

    typedef struct packed {
        logic          load;
        logic [DW-1:0] data;
    } txev_t;

    function automatic sel_e map_addr(input logic [AW-1:0] a, input logic bank);
        case (a)
            3'd0:    return bank ? SEL_DIVLO : SEL_DATA;
            3'd1:    return bank ? SEL_DIVHI : SEL_IEN;
            3'd2:    return SEL_IDFC;
            3'd3:    return SEL_LCTL;
            3'd4:    return SEL_MCTL;
            3'd5:    return SEL_LSTAT;
            3'd6:    return SEL_MSTAT;
            default: return SEL_SCR;
        endcase
    endfunction

    function automatic logic [DW-1:0] len_mask(input logic [WL_W-1:0] wl);
        return {DW{1'b1}} >> (3 - wl);
    endfunction
endpackage

// File: rtl/uhr_decode.sv
module uhr_decode
    import uhr_pkg::*;
(
    input  logic          cs_n,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic          bank,
    output sel_e          sel,
    output logic          rd_en,
    output logic          wr_en
);
    always_comb begin
        rd_en = rd && !cs_n;
        wr_en = wr && !cs_n;
        sel   = (rd_en || wr_en) ? map_addr(addr, bank) : SEL_NONE;
    end
endmodule

// File: rtl/uhr_regs.sv
module uhr_regs
    import uhr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          wr_en,
    input  sel_e          sel,
    input  logic [DW-1:0] wdata,
    output regs_t         q,
    output logic [DW-1:0] scr,
    output txev_t         tx,
    output logic          rx_take
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_IEN:   q.ien   <= wdata;
                SEL_IDFC:  q.fctl  <= wdata;
                SEL_LCTL:  q.lctl  <= wdata;
                SEL_MCTL:  q.mctl  <= wdata;
                SEL_DIVLO: q.divlo <= wdata;
                SEL_DIVHI: q.divhi <= wdata;
                default:   ;
            endcase
        end
    end

    // scratch has no defined reset value
    always_ff @(posedge clk) begin
        if (wr_en && sel == SEL_SCR) scr <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx      <= '0;
            rx_take <= 1'b0;
        end else begin
            tx.load <= wr_en && sel == SEL_DATA;
            if (wr_en && sel == SEL_DATA) tx.data <= wdata;
            rx_take <= rd_en && sel == SEL_DATA;
        end
    end

    // R8: status addresses never update stored state
    p_rostable_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == SEL_LSTAT || sel == SEL_MSTAT)) |=> $stable(q));
    // R5: banked accesses never raise data pulses
    p_bankquiet_r5: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_DIVLO || sel == SEL_DIVHI) |=> (!tx.load && !rx_take));
endmodule

// File: rtl/uhr_rdmux.sv
module uhr_rdmux
    import uhr_pkg::*;
(
    input  logic          rd_en,
    input  sel_e          sel,
    input  regs_t         q,
    input  logic [DW-1:0] scr,
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] id_in,
    input  logic [DW-1:0] lstat_in,
    input  logic [DW-1:0] mstat_in,
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_DATA:  rdata = rx_byte & len_mask(q.lctl[WL_W-1:0]);
                SEL_IEN:   rdata = q.ien;
                SEL_IDFC:  rdata = id_in;
                SEL_LCTL:  rdata = q.lctl;
                SEL_MCTL:  rdata = q.mctl;
                SEL_LSTAT: rdata = lstat_in;
                SEL_MSTAT: rdata = mstat_in;
                SEL_SCR:   rdata = scr;
                SEL_DIVLO: rdata = q.divlo;
                SEL_DIVHI: rdata = q.divhi;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_hostregs.sv
module uart_hostregs
    import uhr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd,
    input  logic          wr,
    input  logic [2:0]    addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic [7:0]    rx_byte,
    input  logic [7:0]    id_in,
    input  logic [7:0]    lstat_in,
    input  logic [7:0]    mstat_in,
    output logic          tx_load,
    output logic [7:0]    tx_byte,
    output logic          rx_take,
    output logic [7:0]    ien_o,
    output logic [7:0]    fctl_o,
    output logic [7:0]    lctl_o,
    output logic [7:0]    mctl_o,
    output logic [15:0]   div_o
);
    sel_e          sel;
    logic          rd_en, wr_en;
    regs_t         q;
    logic [DW-1:0] scr;
    txev_t         tx;

    uhr_decode u_dec (
        .cs_n(cs_n), .rd(rd), .wr(wr), .addr(addr), .bank(q.lctl[BANK_BIT]),
        .sel(sel), .rd_en(rd_en), .wr_en(wr_en)
    );

    uhr_regs u_regs (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .sel(sel),
        .wdata(wdata), .q(q), .scr(scr), .tx(tx), .rx_take(rx_take)
    );

    uhr_rdmux u_mux (
        .rd_en(rd_en), .sel(sel), .q(q), .scr(scr), .rx_byte(rx_byte),
        .id_in(id_in), .lstat_in(lstat_in), .mstat_in(mstat_in), .rdata(rdata)
    );

    assign tx_load = tx.load;
    assign tx_byte = tx.data;
    assign ien_o   = q.ien;
    assign fctl_o  = q.fctl;
    assign lctl_o  = q.lctl;
    assign mctl_o  = q.mctl;
    assign div_o   = {q.divhi, q.divlo};

    // R3: unbanked write at address 0 hands the byte to the transmitter
    p_txload_r3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && wr && addr == 3'd0 && !lctl_o[7]) |=> (tx_load && tx_byte == $past(wdata)));
    // R10: receive pulse only follows an unbanked read at address 0
    p_rxtake_r10: assert property (@(posedge clk) disable iff (rst)
        rx_take |-> $past(!cs_n && rd && addr == 3'd0 && !lctl_o[7]));
    // R9: deselected cycles leave all state alone
    p_nocs_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(div_o) && $stable(ien_o) && $stable(lctl_o) && !tx_load && !rx_take));
    // R1: bus idle when no selected read
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (cs_n || !rd) |-> rdata == 8'h00);
endmodule

// File: tb/uart_hostregs_tb_top.sv
`timescale 1ns/1ps
module uart_hostregs_tb_top;
    logic clk = 0, rst = 1, cs_n = 1, rd = 0, wr = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, rx_byte = 0, id_in = 0, lstat_in = 0, mstat_in = 0;
    logic [7:0] rdata, tx_byte, ien_o, fctl_o, lctl_o, mctl_o;
    logic [15:0] div_o;
    logic tx_load, rx_take;

    int nvec = 0, nbad = 0;
    logic [7:0] m_ien = 0, m_fctl = 0, m_lctl = 0, m_mctl = 0, m_dl = 0, m_dh = 0, m_scr = 0;

    always #2.5 clk = ~clk;

    uart_hostregs dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .id_in(id_in),
        .lstat_in(lstat_in), .mstat_in(mstat_in), .tx_load(tx_load),
        .tx_byte(tx_byte), .rx_take(rx_take), .ien_o(ien_o), .fctl_o(fctl_o),
        .lctl_o(lctl_o), .mctl_o(mctl_o), .div_o(div_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req);
        chk(req, {ien_o, fctl_o, lctl_o, mctl_o}, {m_ien, m_fctl, m_lctl, m_mctl});
        chk(req, div_o, {m_dh, m_dl});
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d, input logic sel);
        logic bank;
        bank = m_lctl[7];
        @(negedge clk);
        cs_n = !sel; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        wr = 0; cs_n = 1;
        if (sel) begin
            case (a)
                3'd0: if (bank) m_dl = d;
                3'd1: if (bank) m_dh = d; else m_ien = d;
                3'd2: m_fctl = d;
                3'd3: m_lctl = d;
                3'd4: m_mctl = d;
                3'd7: m_scr = d;
                default: ;
            endcase
        end
        if (sel && a == 3'd0 && !bank) begin
            chk("R3 pulse", {tx_load, tx_byte}, {1'b1, d});
        end else begin
            chk("R3/R5/R9 no pulse", tx_load, 1'b0);
        end
        chk_outs(sel ? "R4-R8 regs" : "R9 regs");
        @(negedge clk);
        chk("R3 single cycle", tx_load, 1'b0);
    endtask

    task automatic do_rd(input logic [2:0] a, input logic sel, input logic [7:0] exp, input string req);
        logic take;
        take = sel && a == 3'd0 && !m_lctl[7];
        @(negedge clk);
        cs_n = !sel; rd = 1; addr = a;
        #1 chk(req, rdata, exp);
        @(negedge clk);
        rd = 0; cs_n = 1;
        chk("R10 take", rx_take, take);
        #1 chk("R1 idle", rdata, 8'h00);
        @(negedge clk);
        chk("R10 single cycle", rx_take, 1'b0);
    endtask

    initial begin
        #400000;
        nbad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk_outs("R1 reset");
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 pulses", {tx_load, rx_take}, 2'b00);

        // R2 word length sweep, R11 same-cycle data
        for (int wl = 0; wl < 4; wl++) begin
            do_wr(3'd3, 8'(wl), 1);
            for (int p = 0; p < 6; p++) begin
                rx_byte = 8'(p * 8'h53 + 8'hA7);
                do_rd(3'd0, 1, rx_byte & (8'hFF >> (3 - wl)), "R2 rx masked");
            end
        end

        // R3 transmit writes
        for (int v = 0; v < 8; v++) do_wr(3'd0, 8'(v * 37 + 1), 1);

        // R4, R6, R7 across both bank settings
        for (int b = 0; b < 2; b++) begin
            do_wr(3'd3, {b[0], 7'h03}, 1);
            for (int v = 0; v < 4; v++) begin
                logic [7:0] d;
                d = 8'(v * 8'h45 + b * 8'h11 + 5);
                id_in = d ^ 8'h3C; lstat_in = d ^ 8'h5A; mstat_in = d ^ 8'hC3;
                do_wr(3'd1, d, 1);
                do_rd(3'd1, 1, d, b ? "R5 divhi" : "R4 ien");
                do_wr(3'd0, ~d, 1);
                if (b) do_rd(3'd0, 1, ~d, "R5 divlo");
                do_wr(3'd2, d + 8'd1, 1);
                do_rd(3'd2, 1, d ^ 8'h3C, "R6 id");
                do_wr(3'd4, d + 8'd2, 1);
                do_rd(3'd4, 1, d + 8'd2, "R7 mctl");
                do_wr(3'd7, d + 8'd3, 1);
                do_rd(3'd7, 1, d + 8'd3, "R7 scr");
                do_rd(3'd3, 1, m_lctl, "R7 lctl");
                do_rd(3'd5, 1, d ^ 8'h5A, "R7 lstat");
                do_rd(3'd6, 1, d ^ 8'hC3, "R7 mstat");
                do_wr(3'd5, 8'hFF, 1);   // R8
                do_wr(3'd6, 8'hFF, 1);   // R8
                do_rd(3'd7, 1, m_scr, "R8 scr intact");
            end
        end

        // R9 deselected accesses
        for (int a = 0; a < 8; a++) begin
            do_wr(3'(a), 8'h99, 0);
            do_rd(3'(a), 0, 8'h00, "R9 rdata");
        end
        do_wr(3'd3, 8'h00, 1);
        do_wr(3'd0, 8'h77, 0);
        do_rd(3'd0, 0, 8'h00, "R9 rx");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule